// File: doc/BRIEF.md
# Resolution-Mode Runup Sequencer and Averager

This block times the charge-accumulation (runup) phase of an integrating analog-to-digital converter. It also turns the raw per-conversion results into a final reading. A start pulse launches a sequence. The block counts a free-running reference clock and emits a one-cycle strobe when the runup window opens and another when it closes. The window length depends on the selected resolution and on the mains frequency option. After each window closes, the block waits for the external converter to return a signed raw result with a valid flag.

In the coarse mode the raw result is passed through unchanged. In the middle mode the converter develops one decimal digit more than is displayed, and the block removes it by rounding the magnitude half-up. In the finest mode the block runs ten back-to-back runups and sums the ten results. It then divides the sum by ten to form the average. Both division paths share one sequential divide-by-ten unit. The final reading is presented with a one-cycle valid pulse.

The window lengths are computed at elaboration from the reference clock frequency parameter. At 1 MHz the windows are 1667, 16667 and 20000 cycles.

Top module: `runup_sequencer`

## Requirements
- R1: With `mode_sel` = 0 (3.5 digit) or 3 (treated the same), the gap from `runup_begin` to `runup_finish` is round(REF_HZ/600) cycles for either value of `line_50`.
- R2: With `mode_sel` = 1 (4.5 digit), the gap is round(REF_HZ/60) cycles when `line_50` = 0 and round(REF_HZ/50) cycles when `line_50` = 1.
- R3: With `mode_sel` = 2 (5.5 digit), one start produces exactly ten runup windows. Each window has the one-line-cycle length of R2.
- R4: In 5.5-digit mode the reading is sign(S) * floor(|S| / 10), where S is the sum of the ten raw results.
- R5: In 4.5-digit mode the reading is sign(x) * floor((|x| + 5) / 10) for raw result x.
- R6: In 3.5-digit mode the reading equals the raw result.
- R7: A `start` pulse that arrives before the sequence's `reading_valid` has no effect. Each accepted start produces exactly one single-cycle `reading_valid` pulse.
- R8: After reset, `runup_begin`, `runup_finish` and `reading_valid` are low and `reading` is 0.
- R9: A `conv_valid` pulse that arrives while a runup window is open is ignored. Only a result that arrives after `runup_finish` is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a measurement sequence (accepted only when idle) |
| mode_sel | input | 2 | Resolution: 0 = 3.5 digit, 1 = 4.5 digit, 2 = 5.5 digit, 3 = as 0 |
| line_50 | input | 1 | Mains option: 1 = 50 Hz, 0 = 60 Hz |
| conv_data | input | RW | Signed raw result of one conversion |
| conv_valid | input | 1 | `conv_data` is valid this cycle |
| runup_begin | output | 1 | One-cycle strobe: runup window opens |
| runup_finish | output | 1 | One-cycle strobe: runup window closes |
| reading | output | RW | Signed final reading |
| reading_valid | output | 1 | One-cycle strobe: `reading` is new |

## Verification
A miscounted window counter shows up directly as a wrong gap between the two strobes, on the very first runup of the faulty mode. A pass counter or accumulator error stays hidden until the tenth result. It then appears as an extra or missing window, or as a wrong average, about one divider latency after the last raw result. Rounding and sign errors appear in the single reading that follows the affected result. The directed values 14, 15, -15 and the range ends are placed so that an off-by-one rounding or a lost sign changes that reading.

// File: rtl/runup_pkg.sv
package runup_pkg;

    // Number of conversions averaged in the finest mode (fixed by decimal scaling).
    localparam int AVG_N = 10;

    // Resolution select codes seen on mode_sel.
    localparam logic [1:0] MODE_D35 = 2'd0;
    localparam logic [1:0] MODE_D45 = 2'd1;
    localparam logic [1:0] MODE_D55 = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_DIV
    } seq_state_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       line50;
    } seq_cfg_t;

    // Integer division rounded to nearest, used for window lengths.
    function automatic int unsigned div_nearest(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/runup_timer.sv
module runup_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          begin_o,
    output logic          end_o
);

    logic [TW-1:0] cnt;
    logic [TW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            len_q   <= '0;
            begin_o <= 1'b0;
            end_o   <= 1'b0;
        end else begin
            begin_o <= 1'b0;
            end_o   <= 1'b0;
            if (load) begin
                cnt     <= len;
                len_q   <= len;
                begin_o <= 1'b1;
            end else if (cnt != '0) begin
                cnt <= cnt - TW'(1);
                if (cnt == TW'(1)) begin
                    end_o <= 1'b1;
                end
            end
        end
    end

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        end_o |-> !begin_o);  // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= len_q);  // R2

endmodule

// File: rtl/div_by_const.sv
module div_by_const #(
    parameter int DW      = 25,
    parameter int DIVISOR = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] num,
    output logic [DW-1:0] quo,
    output logic          done
);

    localparam int REMW = $clog2(DIVISOR) + 1;
    localparam int CW   = $clog2(DW + 1);

    logic [DW-1:0]   dvd;
    logic [DW-1:0]   num_q;
    logic [REMW-1:0] rem;
    logic [CW-1:0]   cnt;
    logic [REMW:0]   trial;

    always_comb begin
        trial = {rem, dvd[DW-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd   <= '0;
            num_q <= '0;
            rem   <= '0;
            cnt   <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                dvd   <= num;
                num_q <= num;
                rem   <= '0;
                quo   <= '0;
                cnt   <= CW'(DW);
            end else if (cnt != '0) begin
                dvd <= dvd << 1;
                cnt <= cnt - CW'(1);
                if (trial >= (REMW+1)'(DIVISOR)) begin
                    rem <= REMW'(trial - (REMW+1)'(DIVISOR));
                    quo <= {quo[DW-2:0], 1'b1};
                end else begin
                    rem <= trial[REMW-1:0];
                    quo <= {quo[DW-2:0], 1'b0};
                end
                if (cnt == CW'(1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    // Quotient check: q*D <= n < (q+1)*D
    logic [DW+3:0] prod;
    logic [DW+3:0] num_w;
    always_comb begin
        prod  = (DW+4)'(quo) * (DW+4)'(DIVISOR);
        num_w = (DW+4)'(num_q);
    end

    AST_QUOTIENT_EXACT: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod <= num_w) && (num_w - prod < (DW+4)'(DIVISOR)));  // R4

endmodule

// File: rtl/runup_sequencer.sv
module runup_sequencer
    import runup_pkg::*;
#(
    parameter int REF_HZ = 1_000_000,
    parameter int RW     = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           mode_sel,
    input  logic                 line_50,
    input  logic signed [RW-1:0] conv_data,
    input  logic                 conv_valid,
    output logic                 runup_begin,
    output logic                 runup_finish,
    output logic signed [RW-1:0] reading,
    output logic                 reading_valid
);

    localparam int W_TENTH = int'(div_nearest(REF_HZ, 600));
    localparam int W_PLC60 = int'(div_nearest(REF_HZ, 60));
    localparam int W_PLC50 = int'(div_nearest(REF_HZ, 50));
    localparam int TW      = $clog2(W_PLC50 + 1);
    localparam int AW      = RW + $clog2(AVG_N) + 1;
    localparam int PW      = $clog2(AVG_N);
    localparam logic signed [AW-1:0] ACC_LIM = AW'(AVG_N * (2 ** (RW - 1)));

    seq_state_t        state;
    seq_cfg_t          cfg;
    logic [PW-1:0]     pass;
    logic signed [AW-1:0] acc;
    logic              neg_q;
    logic              tload;
    logic              dgo;
    logic [AW-1:0]     dnum;
    logic [AW-1:0]     quo;
    logic              d_done;
    logic              t_end;
    logic [TW-1:0]     win_len;

    // Window selection from latched configuration
    always_comb begin
        unique case (cfg.mode)
            MODE_D45, MODE_D55: win_len = cfg.line50 ? TW'(W_PLC50) : TW'(W_PLC60);
            default:            win_len = TW'(W_TENTH);
        endcase
    end

    runup_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tload),
        .len     (win_len),
        .begin_o (runup_begin),
        .end_o   (t_end)
    );

    assign runup_finish = t_end;

    div_by_const #(.DW(AW), .DIVISOR(10)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (dgo),
        .num  (dnum),
        .quo  (quo),
        .done (d_done)
    );

    // Sign-magnitude preparation of incoming and accumulated values
    logic signed [AW-1:0] conv_ext;
    logic signed [AW-1:0] acc_next;
    logic [AW-1:0]        conv_mag;
    logic [AW-1:0]        acc_mag;

    always_comb begin
        conv_ext = {{(AW-RW){conv_data[RW-1]}}, conv_data};
        acc_next = acc + conv_ext;
        conv_mag = conv_ext[AW-1] ? AW'(-conv_ext) : AW'(conv_ext);
        acc_mag  = acc_next[AW-1] ? AW'(-acc_next) : AW'(acc_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cfg           <= '0;
            pass          <= '0;
            acc           <= '0;
            neg_q         <= 1'b0;
            tload         <= 1'b0;
            dgo           <= 1'b0;
            dnum          <= '0;
            reading       <= '0;
            reading_valid <= 1'b0;
        end else begin
            reading_valid <= 1'b0;
            tload         <= 1'b0;
            dgo           <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg   <= '{mode: mode_sel, line50: line_50};
                        pass  <= '0;
                        acc   <= '0;
                        tload <= 1'b1;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (t_end) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (conv_valid) begin
                        unique case (cfg.mode)
                            MODE_D45: begin
                                neg_q <= conv_data[RW-1];
                                dnum  <= conv_mag + AW'(5);
                                dgo   <= 1'b1;
                                state <= ST_DIV;
                            end
                            MODE_D55: begin
                                if (pass == PW'(AVG_N - 1)) begin
                                    neg_q <= acc_next[AW-1];
                                    dnum  <= acc_mag;
                                    dgo   <= 1'b1;
                                    state <= ST_DIV;
                                end else begin
                                    pass  <= pass + PW'(1);
                                    tload <= 1'b1;
                                    state <= ST_RUN;
                                end
                                acc <= acc_next;
                            end
                            default: begin
                                reading       <= conv_data;
                                reading_valid <= 1'b1;
                                state         <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_DIV: begin
                    if (d_done) begin
                        reading       <= neg_q ? -$signed(quo[RW-1:0]) : $signed(quo[RW-1:0]);
                        reading_valid <= 1'b1;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reading_valid |=> !reading_valid);  // R7
    AST_NO_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !t_end);  // R7
    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (rst)
        pass <= PW'(AVG_N - 1));  // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (acc <= ACC_LIM) && (acc >= -ACC_LIM));  // R4
    AST_QUO_FITS: assert property (@(posedge clk) disable iff (rst)
        d_done |-> (quo[AW-1:RW] == '0));  // R5
    AST_RESULT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !t_end) |=> !(state == ST_DIV || reading_valid));  // R9

endmodule

// File: tb/runup_sequencer_test.sv
module runup_sequencer_test;

    localparam int REF_HZ = 6000;
    localparam int RW     = 20;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [1:0]           mode_sel = 2'd0;
    logic                 line_50 = 1'b0;
    logic signed [RW-1:0] conv_data = '0;
    logic                 conv_valid = 1'b0;
    logic                 runup_begin;
    logic                 runup_finish;
    logic signed [RW-1:0] reading;
    logic                 reading_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int n_begin = 0;
    int n_finish = 0;
    int n_valid = 0;
    int gap_cnt = 0;
    int last_gap = 0;
    logic signed [RW-1:0] last_reading = '0;

    int pass_data[10];

    always #2 clk = ~clk;

    runup_sequencer #(.REF_HZ(REF_HZ), .RW(RW)) uut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .mode_sel      (mode_sel),
        .line_50       (line_50),
        .conv_data     (conv_data),
        .conv_valid    (conv_valid),
        .runup_begin   (runup_begin),
        .runup_finish  (runup_finish),
        .reading       (reading),
        .reading_valid (reading_valid)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Port monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (runup_finish) begin
                last_gap = gap_cnt + 1;
                n_finish = n_finish + 1;
            end
            if (runup_begin) begin
                gap_cnt = 0;
                n_begin = n_begin + 1;
            end else begin
                gap_cnt = gap_cnt + 1;
            end
            if (reading_valid) begin
                n_valid = n_valid + 1;
                last_reading = reading;
            end
        end
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_window(input logic [1:0] m, input logic l50);
        if (m == 2'd1 || m == 2'd2) return l50 ? (REF_HZ + 25) / 50 : (REF_HZ + 30) / 60;
        return (REF_HZ + 300) / 600;
    endfunction

    function automatic int exp_round45(input int x);
        int m;
        m = (x < 0) ? -x : x;
        m = (m + 5) / 10;
        return (x < 0) ? -m : m;
    endfunction

    function automatic int exp_avg55();
        longint s;
        longint m;
        s = 0;
        for (int i = 0; i < 10; i++) s += pass_data[i];
        m = (s < 0) ? -s : s;
        m = m / 10;
        return int'((s < 0) ? -m : m);
    endfunction

    function automatic int rand_val();
        return int'($urandom_range(0, 1048575)) - 524288;
    endfunction

    // Run one complete sequence and report what the ports showed.
    task automatic run_seq(input logic [1:0] m, input logic l50, input bit poke, input bit junk,
                           output int got, output int bad_gap, output int nb, output int nv);
        int b0, v0, f0, npass, t;
        b0 = n_begin; v0 = n_valid; f0 = n_finish;
        bad_gap = -1;
        @(negedge clk);
        mode_sel = m; line_50 = l50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (junk) begin
            conv_data = 20'sd12345; conv_valid = 1'b1;
            @(negedge clk);
            conv_valid = 1'b0;
        end
        npass = (m == 2'd2) ? 10 : 1;
        for (int p = 0; p < npass; p++) begin
            t = 0;
            while (n_finish < f0 + p + 1 && t < 5000) begin
                @(negedge clk);
                t++;
            end
            if (last_gap != exp_window(m, l50)) bad_gap = last_gap;
            if (poke && (p == 3 || p == 9)) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            @(negedge clk);
            conv_data = RW'(pass_data[p]); conv_valid = 1'b1;
            @(negedge clk);
            conv_valid = 1'b0;
        end
        t = 0;
        while (n_valid == v0 && t < 500) begin
            @(negedge clk);
            t++;
        end
        repeat (200) @(negedge clk);
        got = int'(last_reading);
        nb = n_begin - b0;
        nv = n_valid - v0;
    endtask

    task automatic seq_check(input string req, input logic [1:0] m, input logic l50,
                             input bit poke, input bit junk, input int exp);
        int got, bad_gap, nb, nv, npass;
        npass = (m == 2'd2) ? 10 : 1;
        run_seq(m, l50, poke, junk, got, bad_gap, nb, nv);
        check(req, got == exp, got, exp);
        check(req, bad_gap == -1, bad_gap, exp_window(m, l50));
        check("R7 one valid per start", nv == 1, nv, 1);
        check("R3 window count", nb == npass, nb, npass);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R8: reset state
        check("R8 reading_valid", reading_valid == 1'b0, reading_valid, 0);
        check("R8 reading", reading == 0, reading, 0);
        check("R8 runup_begin", runup_begin == 1'b0, runup_begin, 0);
        check("R8 runup_finish", runup_finish == 1'b0, runup_finish, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 idle no strobe", n_begin == 0, n_begin, 0);

        // R1 and R6: coarse mode windows and pass-through
        pass_data[0] = -1234;
        seq_check("R1 R6 mode0 60Hz", 2'd0, 1'b0, 0, 0, -1234);
        pass_data[0] = 524287;
        seq_check("R1 R6 mode0 50Hz", 2'd0, 1'b1, 0, 0, 524287);
        pass_data[0] = -524288;
        seq_check("R1 R6 mode3", 2'd3, 1'b1, 0, 0, -524288);
        // R9: result offered during the window is ignored
        pass_data[0] = 777;
        seq_check("R9 early conv_valid", 2'd0, 1'b0, 0, 1, 777);

        // R2 and R5: middle mode windows and rounding corners
        begin
            int corners[7] = '{14, 15, -15, -14, 0, 524287, -524288};
            for (int i = 0; i < 7; i++) begin
                pass_data[0] = corners[i];
                seq_check("R2 R5 mode1 corner", 2'd1, logic'(i % 2), 0, 0, exp_round45(corners[i]));
            end
            for (int i = 0; i < 6; i++) begin
                pass_data[0] = rand_val();
                seq_check("R2 R5 mode1 random", 2'd1, logic'($urandom_range(0, 1)), 0, 0,
                          exp_round45(pass_data[0]));
            end
            // R9 in rounding mode
            pass_data[0] = 25;
            seq_check("R9 R5 early conv_valid", 2'd1, 1'b0, 0, 1, 3);
        end

        // R3 and R4: ten-pass averaging
        for (int i = 0; i < 10; i++) pass_data[i] = 524287;
        seq_check("R3 R4 all max", 2'd2, 1'b0, 0, 0, exp_avg55());
        for (int i = 0; i < 10; i++) pass_data[i] = -524288;
        seq_check("R3 R4 all min", 2'd2, 1'b1, 0, 0, exp_avg55());
        for (int i = 0; i < 10; i++) pass_data[i] = (i == 0) ? -19 : 0;
        seq_check("R4 small negative", 2'd2, 1'b0, 0, 0, -1);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 10; i++) pass_data[i] = rand_val();
            seq_check("R3 R4 random", 2'd2, logic'(k % 2), 0, 0, exp_avg55());
        end
        // R7: start pulses mid-sequence are ignored
        for (int i = 0; i < 10; i++) pass_data[i] = rand_val();
        seq_check("R7 R4 start ignored", 2'd2, 1'b1, 1, 0, exp_avg55());

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule